// File: doc/BRIEF.md
# Data Memory Address Generator

This block works out the effective data-space address for every load and store of a small 8-bit processor. Register file, I/O registers and SRAM share one flat address space. A request carries a mode code, a 16-bit absolute address, a 6-bit offset and a choice of pointer. The three pointers are 16-bit pairs held in the upper six general registers.

The block reads the chosen pointer from the register-file bytes and forms the address for the mode. For the two auto-modify modes it also produces the new pointer value and a write-back strobe. It decodes which region the address falls in and flags addresses past the last SRAM byte. A request with a mode or pointer combination that is not allowed raises an illegal flag and leaves the pointers untouched.

All results are registered. They appear on the outputs one clock after the request is sampled, where the decoder and the register-file write port pick them up.

Top module: `dmem_agen`

## Requirements
- R1: Mode code 0 (absolute): the effective address equals `abs_addr_i`. There is no write-back, and the pointer choice and the offset have no effect.
- R2: Mode code 1 (pointer): the effective address equals the chosen pointer, with no write-back. Pointer code 0 is the pair formed by bytes 1:0 of `rf_ptr_bytes_i`, code 1 is bytes 3:2 and code 2 is bytes 5:4. Byte k is general register 26+k, and the odd byte of each pair is the high byte.
- R3: Mode code 2 (pointer plus offset) with pointer code 1 or 2: the effective address is the pointer plus the zero-extended 6-bit offset (0 to 63), modulo 2^16, with no write-back.
- R4: Mode code 2 with pointer code 0 sets `illegal_o`, forces the effective address to 0 and the region to code 3 with `out_of_range_o` low, and gives no write-back.
- R5: Mode code 3 (decrement first): the effective address is the pointer minus one, modulo 2^16. `wb_en_o` is high, `wb_value_o` equals the effective address, and `wb_sel_o` equals the pointer code.
- R6: Mode code 4 (increment after): the effective address is the old pointer. `wb_en_o` is high, `wb_value_o` is the pointer plus one modulo 2^16, and `wb_sel_o` equals the pointer code.
- R7: Region decode on `region_o`: code 0 for addresses 0x00-0x1F (registers), code 1 for 0x20-0x5F (I/O), code 2 for 0x60-0xDF (SRAM), and code 3 with `out_of_range_o` high for any address above 0xDF.
- R8: Mode codes 5 to 7, or pointer code 3 in any mode other than absolute, set `illegal_o` with no write-back, an effective address of 0 and region code 3.
- R9: Results appear one clock after a cycle with `req_i` high. After a cycle with `req_i` low, and during reset, `valid_o` and `wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer code (0, 1, 2; 3 invalid) |
| abs_addr_i | input | 16 | Absolute address for mode 0 |
| offset_i | input | 6 | Unsigned offset for mode 2 |
| rf_ptr_bytes_i | input | 48 | General registers 26..31, register 26 in bits 7:0 |
| valid_o | output | 1 | Registered result valid |
| eff_addr_o | output | 16 | Effective data-space address |
| region_o | output | 2 | Region code |
| out_of_range_o | output | 1 | Address above the last SRAM byte |
| illegal_o | output | 1 | Rejected mode/pointer combination |
| wb_en_o | output | 1 | Pointer write-back strobe |
| wb_sel_o | output | 2 | Pointer code to write back |
| wb_value_o | output | 16 | New pointer value |

## Verification
The bench builds the block with its default parameters: 8-bit registers, three pointers, a 6-bit offset and region sizes of 32, 64 and 128. With these values every region edge (0x1F/0x20, 0x5F/0x60, 0xDF/0xE0) can be hit with one offset or one decrement from a chosen pointer. The 16-bit wrap at 0x0000 and 0xFFFF is also within reach of a single step. Directed cases sit on those edges, and a long pseudo-random stream mixes all eight mode codes, all four pointer codes and idle cycles against a behavioural model.

// File: rtl/dmem_agen_pkg.sv
package dmem_agen_pkg;

    typedef enum logic [2:0] {
        AM_ABS     = 3'd0,
        AM_PTR     = 3'd1,
        AM_PTR_OFS = 3'd2,
        AM_DEC_PRE = 3'd3,
        AM_INC_PST = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_NONE = 2'd3
    } region_e;

endpackage

// File: rtl/dmem_agen_ptr_mux.sv
module dmem_agen_ptr_mux #(
    parameter int DATA_W    = 8,
    parameter int PTR_COUNT = 3,
    parameter int SEL_W     = 2
) (
    input  logic [2*DATA_W*PTR_COUNT-1:0] bytes_i,
    input  logic [SEL_W-1:0]              sel_i,
    output logic [2*DATA_W-1:0]           ptr_o,
    output logic                          sel_ok_o
);
    localparam int PW = 2 * DATA_W;

    logic [PW-1:0] pair [PTR_COUNT];

    generate
        for (genvar g = 0; g < PTR_COUNT; g++) begin : g_pair
            // low register first, high register next
            assign pair[g] = {bytes_i[(2*g+1)*DATA_W +: DATA_W],
                              bytes_i[(2*g)*DATA_W   +: DATA_W]};
        end
    endgenerate

    always_comb begin
        ptr_o    = '0;
        sel_ok_o = 1'b0;
        for (int i = 0; i < PTR_COUNT; i++) begin
            if (sel_i == SEL_W'(i)) begin
                ptr_o    = pair[i];
                sel_ok_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmem_agen_calc.sv
module dmem_agen_calc
    import dmem_agen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              ptr_ok_i,
    input  logic              ptr_is_first_i,
    input  logic [ADDR_W-1:0] abs_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_value_o,
    output logic              illegal_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] disp_ext;
    assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp_i};

    always_comb begin
        ea_o       = '0;
        wb_en_o    = 1'b0;
        wb_value_o = '0;
        illegal_o  = 1'b0;
        case (mode_i)
            AM_ABS: ea_o = abs_i;
            AM_PTR: begin
                if (ptr_ok_i) ea_o = ptr_i;
                else          illegal_o = 1'b1;
            end
            AM_PTR_OFS: begin
                if (ptr_ok_i && !ptr_is_first_i) ea_o = ptr_i + disp_ext;
                else                              illegal_o = 1'b1;
            end
            AM_DEC_PRE: begin
                if (ptr_ok_i) begin
                    ea_o       = ptr_i - ONE;
                    wb_value_o = ptr_i - ONE;
                    wb_en_o    = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            AM_INC_PST: begin
                if (ptr_ok_i) begin
                    ea_o       = ptr_i;
                    wb_value_o = ptr_i + ONE;
                    wb_en_o    = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            default: illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dmem_agen_region.sv
module dmem_agen_region
    import dmem_agen_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REG_COUNT  = 32,
    parameter int IO_COUNT   = 64,
    parameter int SRAM_BYTES = 128
) (
    input  logic [ADDR_W-1:0] ea_i,
    output region_e           region_o,
    output logic              oor_o
);
    localparam int IO_BASE_I   = REG_COUNT;
    localparam int SRAM_BASE_I = REG_COUNT + IO_COUNT;
    localparam int END_I       = SRAM_BASE_I + SRAM_BYTES;

    localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(IO_BASE_I);
    localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(SRAM_BASE_I);
    localparam logic [ADDR_W-1:0] SPACE_END = ADDR_W'(END_I);

    always_comb begin
        oor_o = 1'b0;
        if (ea_i < IO_BASE)        region_o = RG_REGS;
        else if (ea_i < SRAM_BASE) region_o = RG_IO;
        else if (ea_i < SPACE_END) region_o = RG_SRAM;
        else begin
            region_o = RG_NONE;
            oor_o    = 1'b1;
        end
    end
endmodule

// File: rtl/dmem_agen.sv
module dmem_agen
    import dmem_agen_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PTR_COUNT  = 3,
    parameter int DISP_W     = 6,
    parameter int REG_COUNT  = 32,
    parameter int IO_COUNT   = 64,
    parameter int SRAM_BYTES = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic [2:0]                    mode_i,
    input  logic [1:0]                    ptr_sel_i,
    input  logic [2*DATA_W-1:0]           abs_addr_i,
    input  logic [DISP_W-1:0]             offset_i,
    input  logic [2*DATA_W*PTR_COUNT-1:0] rf_ptr_bytes_i,
    output logic                          valid_o,
    output logic [2*DATA_W-1:0]           eff_addr_o,
    output logic [1:0]                    region_o,
    output logic                          out_of_range_o,
    output logic                          illegal_o,
    output logic                          wb_en_o,
    output logic [1:0]                    wb_sel_o,
    output logic [2*DATA_W-1:0]           wb_value_o
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam int LAST_I = REG_COUNT + IO_COUNT + SRAM_BYTES - 1;
    localparam logic [ADDR_W-1:0] LAST_SRAM = ADDR_W'(LAST_I);
    localparam logic [ADDR_W-1:0] SRAM_LO   = ADDR_W'(REG_COUNT + IO_COUNT);

    typedef struct packed {
        logic              valid;
        logic [2:0]        mode;
        logic [ADDR_W-1:0] ea;
        region_e           region;
        logic              oor;
        logic              illegal;
        logic              wb_en;
        logic [1:0]        wb_sel;
        logic [ADDR_W-1:0] wb_value;
    } agen_st_s;

    agen_st_s st_d, st_q;

    logic [ADDR_W-1:0] ptr_val;
    logic              ptr_ok;
    logic [ADDR_W-1:0] calc_ea;
    logic              calc_wb_en;
    logic [ADDR_W-1:0] calc_wb_value;
    logic              calc_illegal;
    region_e           dec_region;
    logic              dec_oor;

    dmem_agen_ptr_mux #(
        .DATA_W    (DATA_W),
        .PTR_COUNT (PTR_COUNT),
        .SEL_W     (2)
    ) u_ptr_mux (
        .bytes_i  (rf_ptr_bytes_i),
        .sel_i    (ptr_sel_i),
        .ptr_o    (ptr_val),
        .sel_ok_o (ptr_ok)
    );

    dmem_agen_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_calc (
        .mode_i         (mode_i),
        .ptr_i          (ptr_val),
        .ptr_ok_i       (ptr_ok),
        .ptr_is_first_i (ptr_sel_i == 2'd0),
        .abs_i          (abs_addr_i),
        .disp_i         (offset_i),
        .ea_o           (calc_ea),
        .wb_en_o        (calc_wb_en),
        .wb_value_o     (calc_wb_value),
        .illegal_o      (calc_illegal)
    );

    dmem_agen_region #(
        .ADDR_W     (ADDR_W),
        .REG_COUNT  (REG_COUNT),
        .IO_COUNT   (IO_COUNT),
        .SRAM_BYTES (SRAM_BYTES)
    ) u_region (
        .ea_i     (calc_ea),
        .region_o (dec_region),
        .oor_o    (dec_oor)
    );

    always_comb begin
        st_d = '0;
        st_d.region = RG_NONE;
        if (req_i) begin
            st_d.valid   = 1'b1;
            st_d.mode    = mode_i;
            st_d.illegal = calc_illegal;
            if (!calc_illegal) begin
                st_d.ea       = calc_ea;
                st_d.region   = dec_region;
                st_d.oor      = dec_oor;
                st_d.wb_en    = calc_wb_en;
                st_d.wb_value = calc_wb_value;
                st_d.wb_sel   = calc_wb_en ? ptr_sel_i : 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.region <= RG_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o        = st_q.valid;
    assign eff_addr_o     = st_q.ea;
    assign region_o       = st_q.region;
    assign out_of_range_o = st_q.oor;
    assign illegal_o      = st_q.illegal;
    assign wb_en_o        = st_q.wb_en;
    assign wb_sel_o       = st_q.wb_sel;
    assign wb_value_o     = st_q.wb_value;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !wb_en_o && !illegal_o); // R9
    AST_REQ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o); // R9
    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wb_en_o && !out_of_range_o && eff_addr_o == '0); // R8
    AST_PREDEC_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && st_q.mode == AM_DEC_PRE) |-> wb_value_o == eff_addr_o); // R5
    AST_POSTINC_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && st_q.mode == AM_INC_PST) |-> wb_value_o == eff_addr_o + ADDR_W'(1)); // R6
    AST_NO_WB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.mode < 3'd3) |-> !wb_en_o); // R1
    AST_SRAM_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && region_o == 2'd2) |-> eff_addr_o >= SRAM_LO && eff_addr_o <= LAST_SRAM); // R7
    AST_OOR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range_o |-> eff_addr_o > LAST_SRAM && region_o == 2'd3); // R7
endmodule

// File: tb/dmem_agen_tb.sv
module dmem_agen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  ptr_sel_i = '0;
    logic [15:0] abs_addr_i = '0;
    logic [5:0]  offset_i = '0;
    logic [47:0] rf_ptr_bytes_i = '0;
    logic        valid_o, out_of_range_o, illegal_o, wb_en_o;
    logic [15:0] eff_addr_o, wb_value_o;
    logic [1:0]  region_o, wb_sel_o;

    int n_checks = 0;
    int n_fails  = 0;

    // expected values for the request driven in the previous step
    logic        e_valid;
    logic [15:0] e_ea, e_wbv;
    logic [1:0]  e_region, e_wbsel;
    logic        e_oor, e_ill, e_wb;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_agen u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .ptr_sel_i(ptr_sel_i), .abs_addr_i(abs_addr_i), .offset_i(offset_i),
        .rf_ptr_bytes_i(rf_ptr_bytes_i), .valid_o(valid_o),
        .eff_addr_o(eff_addr_o), .region_o(region_o),
        .out_of_range_o(out_of_range_o), .illegal_o(illegal_o),
        .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_value_o(wb_value_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input bit rq, input int m, input int s,
                         input int abs_a, input int ofs, input logic [47:0] b);
        int p, ea, wbv;
        bit ill, wb;
        e_valid = rq; e_ea = 0; e_wbv = 0; e_region = 3; e_oor = 0;
        e_ill = 0; e_wb = 0; e_wbsel = 0; e_tag = "R9";
        if (!rq) return;
        p = (s < 3) ? int'(b[s*16 +: 16]) : 0;
        ill = 0; wb = 0; ea = 0; wbv = 0;
        case (m)
            0: begin ea = abs_a; e_tag = "R1"; end
            1: begin ill = (s == 3); ea = p; e_tag = "R2"; end
            2: begin ill = (s == 3) || (s == 0); ea = (p + ofs) % 65536;
                     e_tag = (s == 0) ? "R4" : "R3"; end
            3: begin ill = (s == 3); ea = (p + 65535) % 65536; wb = 1; wbv = ea;
                     e_tag = "R5"; end
            4: begin ill = (s == 3); ea = p; wb = 1; wbv = (p + 1) % 65536;
                     e_tag = "R6"; end
            default: begin ill = 1; e_tag = "R8"; end
        endcase
        if (ill && e_tag != "R4") e_tag = "R8";
        e_ill = ill;
        if (!ill) begin
            e_ea = 16'(ea);
            e_wb = wb;
            e_wbv = 16'(wbv);
            e_wbsel = wb ? 2'(s) : 2'd0;
            if (ea < 32)       e_region = 0;
            else if (ea < 96)  e_region = 1;
            else if (ea < 224) e_region = 2;
            else begin e_region = 3; e_oor = 1; end
        end
    endtask

    task automatic compare();
        chk(valid_o == e_valid, "R9", "valid", valid_o, e_valid);
        chk(wb_en_o == e_wb, e_tag, "wb_en", wb_en_o, e_wb);
        if (e_valid) begin
            chk(illegal_o == e_ill, e_tag, "illegal", illegal_o, e_ill);
            chk(eff_addr_o == e_ea, e_tag, "eff_addr", eff_addr_o, e_ea);
            chk(region_o == e_region, (e_ill ? e_tag : "R7"), "region", region_o, e_region);
            chk(out_of_range_o == e_oor, (e_ill ? e_tag : "R7"), "out_of_range", out_of_range_o, e_oor);
            if (e_wb) begin
                chk(wb_value_o == e_wbv, e_tag, "wb_value", wb_value_o, e_wbv);
                chk(wb_sel_o == e_wbsel, e_tag, "wb_sel", wb_sel_o, e_wbsel);
            end
        end
    endtask

    // one cycle: check the result of the previous request, then drive the next
    task automatic step(input bit rq, input int m, input int s, input int abs_a,
                        input int ofs, input logic [47:0] b);
        @(negedge clk);
        compare();
        req_i = rq; mode_i = 3'(m); ptr_sel_i = 2'(s);
        abs_addr_i = 16'(abs_a); offset_i = 6'(ofs); rf_ptr_bytes_i = b;
        model(rq, m, s, abs_a, ofs, b);
    endtask

    function automatic logic [47:0] ptrs(input int x, input int y, input int z);
        return {16'(z), 16'(y), 16'(x)};
    endfunction

    initial begin
        logic [47:0] bank;
        model(0, 0, 0, 0, 0, '0);
        repeat (3) @(negedge clk);
        chk(valid_o == 0 && wb_en_o == 0, "R9", "reset state", {valid_o, wb_en_o}, 0);
        rst_n = 1'b1;

        // R1: absolute, pointer/offset must not matter
        step(1, 0, 3, 16'h001F, 63, ptrs(16'h1234, 16'h5678, 16'h9ABC));
        step(1, 0, 0, 16'h0020, 5, ptrs(0, 0, 0));
        step(1, 0, 1, 16'h00DF, 0, ptrs(1, 2, 3));
        step(1, 0, 2, 16'h00E0, 0, ptrs(1, 2, 3));
        step(1, 0, 2, 16'hFFFF, 0, ptrs(1, 2, 3));
        // R2: pointer pairs, byte order
        bank = {8'h00, 8'h61, 8'h00, 8'h40, 8'h00, 8'h05};
        step(1, 1, 0, 0, 0, bank);
        step(1, 1, 1, 0, 0, bank);
        step(1, 1, 2, 0, 0, {8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
        // R3: offsets to region edges, wrap
        step(1, 2, 1, 0, 63, ptrs(0, 16'h0020, 0));
        step(1, 2, 2, 0, 1,  ptrs(0, 0, 16'h00DF));
        step(1, 2, 2, 0, 63, ptrs(0, 0, 16'hFFF0));
        step(1, 2, 1, 0, 0,  ptrs(0, 16'h005F, 0));
        // R4: offset with the first pointer
        step(1, 2, 0, 0, 10, ptrs(16'h0040, 16'h0040, 16'h0040));
        // R5: decrement first, including wrap at zero
        step(1, 3, 0, 0, 0, ptrs(16'h0060, 0, 0));
        step(1, 3, 1, 0, 0, ptrs(0, 16'h0000, 0));
        step(1, 3, 2, 0, 0, ptrs(0, 0, 16'h0020));
        // R6: increment after, including wrap at 0xFFFF
        step(1, 4, 2, 0, 0, ptrs(0, 0, 16'hFFFF));
        step(1, 4, 0, 0, 0, ptrs(16'h00DF, 0, 0));
        step(0, 4, 1, 0, 0, ptrs(0, 16'h0010, 0));
        // R8: bad mode codes and bad pointer code
        step(1, 5, 1, 16'h0010, 0, ptrs(1, 2, 3));
        step(1, 7, 2, 0, 0, ptrs(1, 2, 3));
        step(1, 3, 3, 0, 0, ptrs(1, 2, 3));
        step(1, 1, 3, 0, 0, ptrs(1, 2, 3));
        step(0, 0, 0, 0, 0, ptrs(1, 2, 3));

        // mixed stream
        for (int i = 0; i < 2000; i++) begin
            int m, s, a, sel;
            logic [47:0] b;
            m = $urandom_range(0, 7);
            if (m > 4 && $urandom_range(0, 3) != 0) m = $urandom_range(0, 4);
            s = $urandom_range(0, 3);
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 300);
            for (int k = 0; k < 3; k++) begin
                int v;
                v = (sel == 3) ? (($urandom_range(0, 1) == 1) ? 65535 : 0)
                               : $urandom_range(0, 260);
                if (sel == 0) v = $urandom_range(0, 65535);
                b[k*16 +: 16] = 16'(v);
            end
            step($urandom_range(0, 5) != 0, m, s, a, $urandom_range(0, 63), b);
        end
        step(0, 0, 0, 0, 0, '0);
        step(0, 0, 0, 0, 0, '0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule